// File: doc/BRIEF.md
# SPI Host Controller with Shared-Bus Select Monitoring

This block is a byte-wide SPI host for buses where more than one host may drive the clock. It shifts one byte out on MOSI and one byte in from MISO. SCK runs at a fixed quarter of the system clock in SPI mode 0, and the most significant bit goes first. Software programs it through three write strobes: a control word, a write-one-to-clear flag word and a data word. It reads the mode and flag state from plain status outputs.

The select pin can be watched as an input. When it is, a low level from a competing host counts as a mode fault. The block then leaves host mode, aborts any byte in flight and stops driving SCK and MOSI. It also sets a fault flag, which requests an interrupt when the interrupt enable is set. Host mode stays off until software sets it again. The select pin can instead be made an output, or the monitor can be disabled outright. In both of those cases the pin level never affects the controller.

Top module: `spi_mh_host`

## Requirements
- R1: After reset, host mode is off, the fault and done flags are 0, `irq` is 0, SCK is low and the SCK and MOSI output enables are 0.
- R2: The control word is written by `ctrl_we`, with bit0 = host enable, bit1 = select-monitor disable, bit2 = select pin is an output and bit3 = fault interrupt enable. A data write while host mode is off starts no transfer, and SCK stays low.
- R3: A data write in host mode while idle sends 8 bits MSB first in SPI mode 0. SCK idles low and is low for 2 and high for 2 system clocks per bit, and MISO is captured on each SCK rise. The done flag sets 32 clocks after the write edge, and `rx_data` then holds the received byte. A data write while busy is ignored.
- R4: With select-monitor disable = 1, a low select input never affects host mode or the fault flag.
- R5: With select-monitor disable = 0 and the select pin set as an output, the select level has no effect. `ss_oe` follows the direction bit.
- R6: With the monitor enabled and the select pin an input held high, host mode stays on.
- R7: With the monitor enabled and the select pin an input, a low select level passes through a two-flop synchroniser. On the third clock edge after the pin falls, host enable clears and the fault flag sets.
- R8: `irq` is high exactly when the fault flag and the fault interrupt enable are both 1.
- R9: After a mode fault, host enable stays 0 when the select pin returns high, until software writes it to 1. A fault in the same cycle as a control write wins.
- R10: In host mode the SCK and MOSI output enables are 1. After a fault both are 0. The MISO output enable is always 0.
- R11: A fault during a transfer aborts it at once: busy drops, SCK goes low and the done flag is not set.
- R12: Writing 1 to flag bit0 (fault) or bit1 (done) clears that flag. A clear of the fault flag in the same cycle as a new fault leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word: {irq_en, ss_is_out, mon_dis, host_en} |
| flag_we | input | 1 | Flag clear strobe |
| flag_wdata | input | 2 | Write-one-to-clear: bit1 done, bit0 fault |
| data_we | input | 1 | Transmit byte write strobe |
| data_wdata | input | 8 | Byte to send |
| host_en | output | 1 | Host mode enable state |
| fault_flag | output | 1 | Mode-fault flag |
| done_flag | output | 1 | Transfer-complete flag |
| irq | output | 1 | Fault interrupt request |
| busy | output | 1 | Transfer in progress |
| rx_data | output | 8 | Last received byte |
| ss_i | input | 1 | Select pin input level |
| ss_oe | output | 1 | Select pin output enable |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in |
| miso_oe | output | 1 | Serial data output enable (always 0) |

## Verification
The bench checks the exact fault latency. A design that skips or doubles the synchroniser clears host enable one edge too early or too late. It pulls the select line low in the middle of a byte; a design that only halts between bytes would keep clocking SCK or go on to set the done flag. It also issues a flag clear in the same cycle as a fresh fault, where a clear-wins priority would lose the event. Finally, it returns the select line high after a fault, which exposes a design that re-enables host mode by itself. The select pin is also held low with monitoring disabled and with the pin as an output, to show that neither setting can trip a fault.

// File: rtl/spi_mh_host.sv
module spi_mh_host #(
  parameter int DW   = 8,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [3:0]    ctrl_wdata,
  input  logic          flag_we,
  input  logic [1:0]    flag_wdata,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  output logic          host_en,
  output logic          fault_flag,
  output logic          done_flag,
  output logic          irq,
  output logic          busy,
  output logic [DW-1:0] rx_data,
  input  logic          ss_i,
  output logic          ss_oe,
  output logic          sck_o,
  output logic          sck_oe,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_oe
);
  localparam int PER = 2 * HALF;
  localparam int PW  = $clog2(PER);
  localparam int BW  = $clog2(DW);

  logic          mon_dis, ss_out, irq_en;
  logic [1:0]    ss_sync;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          fault, start, ph_end, last_bit;

  assign fault    = host_en & ~mon_dis & ~ss_out & ~ss_sync[1];
  assign start    = data_we & host_en & ~busy & ~fault;
  assign ph_end   = (ph == PW'(PER - 1));
  assign last_bit = (bitn == BW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ss_sync <= 2'b11;
    else        ss_sync <= {ss_sync[0], ss_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      host_en <= 1'b0;
      mon_dis <= 1'b0;
      ss_out  <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        host_en <= ctrl_wdata[0];
        mon_dis <= ctrl_wdata[1];
        ss_out  <= ctrl_wdata[2];
        irq_en  <= ctrl_wdata[3];
      end
      if (fault) host_en <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fault_flag <= 1'b0;
    else if (fault) fault_flag <= 1'b1;
    else if (flag_we && flag_wdata[0]) fault_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      ph        <= '0;
      bitn      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_data   <= '0;
      done_flag <= 1'b0;
    end else begin
      if (flag_we && flag_wdata[1]) done_flag <= 1'b0;
      if (fault) begin
        busy <= 1'b0;
        ph   <= '0;
        bitn <= '0;
      end else if (start) begin
        busy  <= 1'b1;
        ph    <= '0;
        bitn  <= '0;
        tx_sh <= data_wdata;
      end else if (busy) begin
        ph <= ph_end ? '0 : ph + 1'b1;
        if (ph == PW'(HALF - 1)) rx_sh <= {rx_sh[DW-2:0], miso_i};
        if (ph_end) begin
          tx_sh <= {tx_sh[DW-2:0], 1'b0};
          bitn  <= bitn + 1'b1;
          if (last_bit) begin
            busy      <= 1'b0;
            done_flag <= 1'b1;
            rx_data   <= rx_sh;
          end
        end
      end
    end

  assign irq     = fault_flag & irq_en;
  assign sck_o   = busy & (ph >= PW'(HALF));
  assign mosi_o  = tx_sh[DW-1];
  assign sck_oe  = host_en;
  assign mosi_oe = host_en;
  assign miso_oe = 1'b0;
  assign ss_oe   = ss_out;

  a_r7_fault_drops_host: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !host_en);
  a_r12_fault_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault_flag);
  a_r11_fault_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!busy && !sck_o));
  a_r9_host_falls_only_by_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_en) |-> ($past(fault) || $past(ctrl_we && !ctrl_wdata[0])));
  a_r4_ignored_select_keeps_host: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && (mon_dis || ss_out) && !ctrl_we) |=> host_en);
  a_r2_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && !busy) |=> !busy);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(busy));
endmodule

// File: tb/spi_mh_host_tb.sv
module spi_mh_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [8:0] VEC [NVEC] = '{9'h0A5, 9'h13C, 9'h000, 9'h1FF, 9'h081, 9'h15A};

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, flag_we = 0, data_we = 0;
  logic [3:0] ctrl_wdata = 0;
  logic [1:0] flag_wdata = 0;
  logic [7:0] data_wdata = 0;
  logic host_en, fault_flag, done_flag, irq, busy;
  logic [7:0] rx_data;
  logic ss_i = 1, ss_oe, sck_o, sck_oe, mosi_o, mosi_oe, miso_oe;
  logic inv = 0;
  logic miso_i;
  logic [7:0] cap = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso_i = inv ? ~mosi_o : mosi_o;
  always @(posedge sck_o) cap <= {cap[6:0], mosi_o};

  spi_mh_host u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wctrl(input logic [3:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wflag(input logic [1:0] v);
    @(negedge clk); flag_we = 1; flag_wdata = v;
    @(negedge clk); flag_we = 0;
  endtask

  task automatic wdata(input logic [7:0] v);
    @(negedge clk); data_we = 1; data_wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    idle(2);
    chk(!host_en && !fault_flag && !done_flag && !irq && !sck_o && !sck_oe && !mosi_oe,
        "R1 reset state", {host_en, fault_flag, done_flag, irq, sck_o, sck_oe, mosi_oe}, 0);
    rst_n = 1;
    idle(2);

    wdata(8'h55);
    idle(6);
    chk(!busy && !sck_o, "R2 write with host off", {busy, sck_o}, 0);

    wctrl(4'b1001);
    chk(sck_oe && mosi_oe && !miso_oe, "R10 host drives pins", {sck_oe, mosi_oe, miso_oe}, 3'b110);

    for (int v = 0; v < NVEC; v++) begin
      inv = VEC[v][8];
      wdata(VEC[v][7:0]);
      @(negedge clk); data_we = 1; data_wdata = 8'hEE;
      @(negedge clk); data_we = 0;
      n = 2;
      while (!done_flag && n < 100) begin @(negedge clk); n++; end
      chk(n == 32, "R3 transfer length", n, 32);
      chk(cap == VEC[v][7:0], "R3 MSB-first mosi", cap, VEC[v][7:0]);
      chk(rx_data == (inv ? ~VEC[v][7:0] : VEC[v][7:0]), "R3 received byte",
          rx_data, inv ? ~VEC[v][7:0] : VEC[v][7:0]);
      wflag(2'b10);
      chk(!done_flag, "R12 done clear", done_flag, 0);
    end
    inv = 0;

    ss_i = 0;
    wctrl(4'b1011);
    idle(8);
    chk(host_en && !fault_flag, "R4 monitor disabled", {host_en, fault_flag}, 2'b10);
    wctrl(4'b1101);
    idle(8);
    chk(host_en && !fault_flag && ss_oe, "R5 select as output", {host_en, fault_flag, ss_oe}, 3'b101);
    ss_i = 1;
    idle(4);
    wctrl(4'b1001);
    idle(8);
    chk(host_en && !fault_flag, "R6 select high input", {host_en, fault_flag}, 2'b10);

    wdata(8'hC3);
    idle(8);
    ss_i = 0;
    idle(2);
    chk(host_en && busy, "R7 host before third edge", {host_en, busy}, 2'b11);
    idle(1);
    chk(!host_en && fault_flag, "R7 fault latency", {host_en, fault_flag}, 2'b01);
    chk(irq, "R8 irq with enable", irq, 1);
    chk(!busy && !sck_o, "R11 transfer aborted", {busy, sck_o}, 0);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R10 pins released", {sck_oe, mosi_oe, miso_oe}, 0);
    idle(40);
    chk(!done_flag, "R11 no done after abort", done_flag, 0);

    @(negedge clk); ctrl_we = 1; ctrl_wdata = 4'b0001;
    @(negedge clk); ctrl_we = 0; flag_we = 1; flag_wdata = 2'b01;
    @(negedge clk); flag_we = 0;
    chk(fault_flag && !host_en, "R12 clear loses to fault", {fault_flag, host_en}, 2'b10);
    chk(!irq, "R8 irq masked", irq, 0);

    ss_i = 1;
    idle(10);
    chk(!host_en, "R9 host stays off", host_en, 0);
    wflag(2'b01);
    chk(!fault_flag, "R12 fault clear", fault_flag, 0);
    wdata(8'h0F);
    idle(5);
    chk(!busy && !sck_o, "R2 no start after fault", {busy, sck_o}, 0);
    wctrl(4'b0001);
    chk(host_en && sck_oe, "R9 software re-enable", {host_en, sck_oe}, 2'b11);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule